// File: doc/BRIEF.md
# Tester-Driven Bus Master Bridge

This block lets an external tester drive the on-chip system bus during manufacturing test. The tester uses a slow handshake with three wires. A two-bit request code tells the block what kind of vector is on the 32-bit data input. The block raises a single acknowledge line whenever it can take the next vector. On the bus side, the block acts as a master on an AHB-style bus. It issues one single-beat, full-word transfer for each write or read vector.

Test mode is chosen only at reset. If the test-enable pin is high during reset and still high on the first clock after reset is released, the block latches test mode. From then on it holds its bus request high. Once the arbiter grants the bus, it serves vectors. An address vector loads the transfer address. Each completed read or write moves that address on by one word, so consecutive locations can be streamed without reloading. Read data is returned on a separate 32-bit output bus.

Top module: `tvec_bus_master`

## Requirements
- R1: While test mode is not latched, `bus_req`, `tack`, `haddr`, `htrans`, `hwrite`, `hsize` and `hwdata` are all zero, and request codes on `vec_req` start no bus transfer.
- R2: Test mode is latched when `test_en` is high on the last clock with `rst_n` low and also on the first clock after `rst_n` goes high. Raising `test_en` later does not enter test mode. Dropping it after entry does not leave test mode; only a reset does.
- R3: Once test mode is latched, `bus_req` stays high. `tack` is high only when the block is ready for a vector and `bus_grant` is high.
- R4: Request codes on `vec_req` are: 2'b00 idle, 2'b01 load address, 2'b10 write, 2'b11 read. A nonzero code is accepted on a rising edge where `tack` is high, and `tack` is low on the next cycle. `tack` returns high only after the code has gone back to 2'b00.
- R5: A write vector produces exactly one address phase with `htrans`=2'b10, `hwrite`=1, `hsize`=3'b010 and `haddr` equal to the held address. The vector data appears on `hwdata` in the following data phase.
- R6: A read vector produces one read transfer. The returned `hrdata` appears on `vec_dout` before `tack` rises. It stays there unchanged until the next vector is accepted, at which point `vec_dout` becomes zero.
- R7: The held address increases by 4 after each completed read or write. A load-address vector starts no bus transfer.
- R8: While the slave holds `hready` low, the transfer stays where it is and `tack` stays low.
- R9: With `bus_grant` low, no address phase is issued (`htrans`=2'b00), no vector is accepted and `tack` is low. The pending work resumes when the grant returns.
- R10: After reset, `vec_dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| test_en | input | 1 | Test-mode selection, sampled around reset release |
| vec_req | input | 2 | Tester request code |
| vec_din | input | 32 | Tester vector data (address or write data) |
| tack | output | 1 | Ready for the next vector |
| vec_dout | output | 32 | Read data returned to the tester |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| haddr | output | 32 | Transfer address |
| htrans | output | 2 | Transfer type (2'b10 issued, 2'b00 idle) |
| hwrite | output | 1 | Transfer direction, 1 for write |
| hsize | output | 3 | Transfer size, word during test |
| hwdata | output | 32 | Write data |
| hrdata | input | 32 | Read data |
| hready | input | 1 | Slave ready / transfer done |

## Verification
The bench builds the block with its default widths: 32-bit data and 32-bit address, which gives a 4-byte address step. It attaches a 16-word slave model, so every address the bench uses lies between 0x00 and 0x3C. At these widths the bench can cover several things:
- address auto-increment across a write run and a read-back run;
- wait states inserted through `hready`;
- grant withdrawal before a vector is accepted and in the middle of a transfer;
- the two reset-time cases of the test-enable pin.

// File: rtl/tvb_pkg.sv
// Shared encodings for the tester-driven bus master.
// Assumes a 2-bit tester request code and an AHB-style transfer encoding.
package tvb_pkg;

    typedef enum logic [1:0] {
        VEC_IDLE  = 2'b00,
        VEC_ADDR  = 2'b01,
        VEC_WRITE = 2'b10,
        VEC_READ  = 2'b11
    } vec_kind_e;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_ACQUIRE = 3'd1,
        ST_READY   = 3'd2,
        ST_ADDR_PH = 3'd3,
        ST_DATA_PH = 3'd4,
        ST_RELEASE = 3'd5
    } seq_state_e;

    localparam logic [1:0] HTRANS_IDLE   = 2'b00;
    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
    localparam logic [2:0] HSIZE_WORD    = 3'b010;

endpackage

// File: rtl/tvb_mode_latch.sv
// Decides once per reset whether test mode is entered.
// Assumes: test_en is stable around reset release; mode is left only by reset.
module tvb_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    output logic mode_on
);

    logic armed;

    // Arm during reset, confirm on the first clock after release, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= test_en;
            mode_on <= 1'b0;
        end else begin
            mode_on <= mode_on | (armed & test_en);
            armed   <= 1'b0;
        end
    end

endmodule

// File: rtl/tvb_seq.sv
// Handshake and transfer sequencer: accepts tester vectors and steps a single
// bus transfer through its address and data phases.
// Assumes: the tester returns its request to idle before the next vector.
module tvb_seq
    import tvb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_on,
    input  logic [1:0] vec_req,
    input  logic       bus_grant,
    input  logic       hready,
    output seq_state_e state,
    output logic       accept,
    output vec_kind_e  kind_q,
    output logic       xfer_done
);

    seq_state_e state_nx;
    vec_kind_e  req_kind;

    assign req_kind  = vec_kind_e'(vec_req);
    assign accept    = (state == ST_READY) && bus_grant && (req_kind != VEC_IDLE);
    assign xfer_done = (state == ST_DATA_PH) && bus_grant && hready;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:     if (mode_on) state_nx = ST_ACQUIRE;
            ST_ACQUIRE: if (bus_grant) state_nx = ST_READY;
            ST_READY: begin
                if (accept) begin
                    state_nx = (req_kind == VEC_ADDR) ? ST_RELEASE : ST_ADDR_PH;
                end
            end
            ST_ADDR_PH: if (bus_grant && hready) state_nx = ST_DATA_PH;
            ST_DATA_PH: if (xfer_done) state_nx = ST_RELEASE;
            ST_RELEASE: if (req_kind == VEC_IDLE) state_nx = ST_READY;
            default:    state_nx = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Remember which vector kind is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)      kind_q <= VEC_IDLE;
        else if (accept) kind_q <= req_kind;
    end

endmodule

// File: rtl/tvb_datapath.sv
// Address, write-data and read-data holding registers.
// Assumes ADDR_W <= DATA_W; the address is loaded from the low vector bits.
module tvb_datapath
    import tvb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        vec_req,
    input  logic [DATA_W-1:0] vec_din,
    input  logic              xfer_done,
    input  vec_kind_e         kind_q,
    input  logic [DATA_W-1:0] hrdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    localparam int ADDR_STEP = DATA_W / 8;

    vec_kind_e req_kind;
    assign req_kind = vec_kind_e'(vec_req);

    // Held address: loaded by an address vector, stepped after each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                               addr_q <= '0;
        else if (accept && req_kind == VEC_ADDR)  addr_q <= vec_din[ADDR_W-1:0];
        else if (xfer_done)                       addr_q <= addr_q + ADDR_W'(ADDR_STEP);
    end

    // Write data captured at acceptance of a write vector.
    always_ff @(posedge clk) begin
        if (!rst_n)                               wdata_q <= '0;
        else if (accept && req_kind == VEC_WRITE) wdata_q <= vec_din;
    end

    // Read data: cleared on any acceptance, filled on read completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata_q <= '0;
        else if (accept)                           rdata_q <= '0;
        else if (xfer_done && kind_q == VEC_READ)  rdata_q <= hrdata;
    end

endmodule

// File: rtl/tvec_bus_master.sv
// Top: bridges a three-wire tester handshake onto an AHB-style bus master.
// Assumes a single-beat word transfer per vector and an arbiter that may
// withdraw the grant at any cycle.
module tvec_bus_master
    import tvb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic [1:0]        vec_req,
    input  logic [DATA_W-1:0] vec_din,
    output logic              tack,
    output logic [DATA_W-1:0] vec_dout,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready
);

    logic              mode_on;
    seq_state_e        state;
    logic              accept;
    vec_kind_e         kind_q;
    logic              xfer_done;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_addr_ph;
    logic              in_data_ph;

    tvb_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .mode_on (mode_on)
    );

    tvb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_on   (mode_on),
        .vec_req   (vec_req),
        .bus_grant (bus_grant),
        .hready    (hready),
        .state     (state),
        .accept    (accept),
        .kind_q    (kind_q),
        .xfer_done (xfer_done)
    );

    tvb_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .vec_req   (vec_req),
        .vec_din   (vec_din),
        .xfer_done (xfer_done),
        .kind_q    (kind_q),
        .hrdata    (hrdata),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q)
    );

    assign in_addr_ph = (state == ST_ADDR_PH);
    assign in_data_ph = (state == ST_DATA_PH);

    // Tester-side outputs.
    assign bus_req  = mode_on;
    assign tack     = (state == ST_READY) && bus_grant;
    assign vec_dout = rdata_q;

    // Bus drive: quiet outside the owning phase.
    assign haddr  = in_addr_ph ? addr_q : '0;
    assign htrans = (in_addr_ph && bus_grant) ? HTRANS_NONSEQ : HTRANS_IDLE;
    assign hwrite = in_addr_ph && (kind_q == VEC_WRITE);
    assign hsize  = in_addr_ph ? HSIZE_WORD : 3'b000;
    assign hwdata = (in_data_ph && kind_q == VEC_WRITE) ? wdata_q : '0;

endmodule

// File: rtl/tvb_checker.sv
// Protocol properties for tvec_bus_master, attached with bind.
module tvb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        vec_req,
    input logic              tack,
    input logic [DATA_W-1:0] vec_dout,
    input logic              bus_req,
    input logic              bus_grant,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic              hwrite,
    input logic [2:0]        hsize,
    input logic [DATA_W-1:0] hwdata
);

    AST_QUIET_OUTSIDE_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (!tack && htrans == 2'b00 && !hwrite && haddr == '0 && hwdata == '0)); // R1

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_req); // R2

    AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        tack |-> (bus_grant && bus_req)); // R3

    AST_ACK_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tack && vec_req != 2'b00) |=> !tack); // R4

    AST_WORD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> (hsize == 3'b010 && !tack)); // R5

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tack && vec_req == 2'b00) |=> $stable(vec_dout)); // R6

    AST_NO_ISSUE_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> bus_grant); // R9

endmodule

bind tvec_bus_master tvb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_req   (vec_req),
    .tack      (tack),
    .vec_dout  (vec_dout),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hwdata    (hwdata)
);

// File: tb/sim_tvec_bus_master.sv
module sim_tvec_bus_master;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] data;
        logic [31:0] expect_v;
    } vec_row_t;

    // kind: 01 load address, 10 write (expect = bus address), 11 read (expect = data)
    localparam vec_row_t VEC_TABLE [8] = '{
        '{2'b01, 32'h0000_0010, 32'h0},
        '{2'b10, 32'hA5A5_0001, 32'h0000_0010},
        '{2'b10, 32'h0000_BEEF, 32'h0000_0014},
        '{2'b10, 32'h1234_5678, 32'h0000_0018},
        '{2'b01, 32'h0000_0010, 32'h0},
        '{2'b11, 32'h0,         32'hA5A5_0001},
        '{2'b11, 32'h0,         32'h0000_BEEF},
        '{2'b11, 32'h0,         32'h1234_5678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0;
    logic [1:0]  vec_req = 2'b00;
    logic [31:0] vec_din = '0;
    logic        tack;
    logic [31:0] vec_dout;
    logic        bus_req;
    logic        bus_grant;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [31:0] hwdata;
    logic [31:0] hrdata;
    logic        hready;

    logic        grant_en = 1'b1;
    logic        stall = 1'b0;

    int checks = 0;
    int errors = 0;

    // Slave model state.
    logic [31:0] mem [16];
    logic        pend = 1'b0;
    logic        pwr = 1'b0;
    logic [3:0]  pidx = '0;
    logic [31:0] paddr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [2:0]  last_size = '0;
    int          issue_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_grant = bus_req & grant_en;
    assign hready    = ~stall;
    assign hrdata    = mem[pidx];

    tvec_bus_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .vec_req   (vec_req),
        .vec_din   (vec_din),
        .tack      (tack),
        .vec_dout  (vec_dout),
        .bus_req   (bus_req),
        .bus_grant (bus_grant),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hwdata    (hwdata),
        .hrdata    (hrdata),
        .hready    (hready)
    );

    // Simple pipelined word slave.
    always @(posedge clk) begin
        if (hready) begin
            if (pend && pwr) begin
                mem[pidx]    <= hwdata;
                last_wr_addr <= paddr;
            end
            pend  <= htrans[1];
            pwr   <= hwrite;
            paddr <= haddr;
            pidx  <= haddr[5:2];
            if (htrans[1]) begin
                issue_cnt <= issue_cnt + 1;
                last_size <= hsize;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic wait_ack(input string tag);
        for (int i = 0; i < 200; i++) begin
            if (tack) break;
            @(negedge clk);
        end
        if (!tack) check(tag, 32'(tack), 32'd1);
    endtask

    task automatic apply_vector(input logic [1:0] kind, input logic [31:0] data);
        wait_ack("R4 ready before vector");
        vec_req = kind;
        vec_din = data;
        @(negedge clk);
        check("R4 ack low after accept", 32'(tack), 32'd0);
        vec_req = 2'b00;
        wait_ack("R4 ack returns");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt0;
        logic [31:0] held;

        // Reset without test enable: stays out of test mode.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 no mode without test_en", 32'(bus_req), 32'd0);
        check("R1 tack low", 32'(tack), 32'd0);
        check("R1 htrans idle", 32'(htrans), 32'd0);
        check("R10 vec_dout zero", vec_dout, 32'd0);
        vec_req = 2'b10;
        vec_din = 32'hDEAD_0000;
        repeat (3) @(negedge clk);
        check("R1 request ignored", 32'(issue_cnt), 32'd0);
        check("R1 haddr zero", haddr, 32'd0);
        vec_req = 2'b00;
        test_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 late test_en ignored", 32'(bus_req), 32'd0);

        // Reset with test enable: mode latched.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 bus_req after entry", 32'(bus_req), 32'd1);
        wait_ack("R3 ack after grant");
        test_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 mode held after test_en drop", 32'(bus_req), 32'd1);
        check("R10 vec_dout zero in mode", vec_dout, 32'd0);

        // Table walk.
        for (int r = 0; r < 8; r++) begin
            cnt0 = issue_cnt;
            apply_vector(VEC_TABLE[r].kind, VEC_TABLE[r].data);
            if (VEC_TABLE[r].kind == 2'b01) begin
                check("R7 load issues nothing", 32'(issue_cnt), 32'(cnt0));
            end else if (VEC_TABLE[r].kind == 2'b10) begin
                check("R5 write address", last_wr_addr, VEC_TABLE[r].expect_v);
                check("R5 write data", mem[VEC_TABLE[r].expect_v[5:2]], VEC_TABLE[r].data);
                check("R5 word size", 32'(last_size), 32'd2);
                check("R7 one transfer", 32'(issue_cnt), 32'(cnt0 + 1));
            end else begin
                check("R6 read data", vec_dout, VEC_TABLE[r].expect_v);
            end
        end

        // Read data held while idle, cleared on next acceptance.
        held = vec_dout;
        repeat (5) @(negedge clk);
        check("R6 read data held", vec_dout, held);
        apply_vector(2'b01, 32'h0000_0014);
        check("R6 cleared by next vector", vec_dout, 32'd0);

        // Wait states on a read.
        stall = 1'b1;
        wait_ack("R8 ready");
        vec_req = 2'b11;
        @(negedge clk);
        vec_req = 2'b00;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 tack low during stall", 32'(tack), 32'd0);
        end
        stall = 1'b0;
        wait_ack("R8 completes");
        check("R8 read after wait states", vec_dout, 32'h0000_BEEF);
        apply_vector(2'b11, 32'h0);
        check("R7 address stepped", vec_dout, 32'h1234_5678);

        // Grant removed before acceptance.
        wait_ack("R9 ready");
        grant_en = 1'b0;
        vec_req  = 2'b10;
        vec_din  = 32'hCAFE_0000;
        cnt0 = issue_cnt;
        @(negedge clk);
        check("R9 tack low without grant", 32'(tack), 32'd0);
        repeat (3) @(negedge clk);
        check("R9 no issue without grant", 32'(issue_cnt), 32'(cnt0));
        grant_en = 1'b1;
        @(negedge clk);
        vec_req = 2'b00;
        wait_ack("R9 resumes");
        check("R9 write after grant return", mem[7], 32'hCAFE_0000);
        check("R7 write address 0x1C", last_wr_addr, 32'h0000_001C);

        // Grant removed mid transfer.
        apply_vector(2'b01, 32'h0000_001C);
        stall = 1'b1;
        wait_ack("R9 ready mid");
        vec_req = 2'b11;
        @(negedge clk);
        vec_req = 2'b00;
        grant_en = 1'b0;
        stall = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 waits mid transfer", 32'(tack), 32'd0);
        check("R9 no data yet", vec_dout, 32'd0);
        grant_en = 1'b1;
        wait_ack("R9 mid resumes");
        check("R9 read after resume", vec_dout, 32'hCAFE_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule